// File: doc/BRIEF.md
# Region-Based Wait-State Access Sequencer

This block paces single bus accesses. It decodes each accepted request address into one of several memory or I/O regions, works out how many clock cycles that region needs, and holds the access open for exactly that many cycles. The region code and a setup, wait or hold phase strobe are shown in every cycle of the access. A one-cycle ready pulse marks the final cycle.

The cycle count depends on the region, on the access direction and on a set of configuration fields. These fields are a fast-read enable for program flash, flash wait and hold counts, a zero-wait-state select for data EEPROM, I/O wait and hold counts, and an extra-write count that lengthens writes to flash and to the port window. All configuration inputs are captured when the request is accepted. A change to them part way through an access therefore has no effect on that access.

The surrounding bus logic presents a request while the block is idle. It then waits for ready before it issues the next one. The memory arrays, flash programming time and the peripherals themselves are outside this block.

Top module: `access_pacer`

## Requirements
- R1: A read at 0x0000–0xBFFF (program flash) lasts 1 cycle when `flashFastRd` is 1. When `flashFastRd` is 0 it lasts 2 + `flashWait` + `flashHold` cycles.
- R2: A flash write lasts 1 + `extraWr` cycles when `flashFastRd` is 1. When `flashFastRd` is 0 it lasts 2 + `extraWr` + `flashWait` + `flashHold` cycles.
- R3: Any access at 0xC000–0xCBFF (static RAM) lasts 1 cycle, whatever the configuration inputs are.
- R4: An access at 0xF000–0xF27F (data EEPROM) lasts 1 cycle when `eeZeroWs` is 1 and 2 cycles when it is 0.
- R5: An access at 0xF800–0xFFFF outside the port window (on-chip peripherals) lasts a fixed 2 cycles.
- R6: In the port window 0xFB00–0xFBFF, a read lasts 3 + `ioWait` + `ioHold` cycles and a write lasts 3 + `extraWr` + `ioWait` + `ioHold` cycles.
- R7: An address in none of the regions above lasts 1 cycle and raises `decodeErr` during that cycle.
- R8: A request is accepted on a clock edge where `reqValid` is 1 and `busy` is 0. `busy` is 1 from the next cycle through the last cycle of the access. `ready` is 1 for exactly one cycle, the last one. The cycle after `ready` is always idle, and requests are ignored while `busy` is 1.
- R9: Exactly one of `phaseSetup`, `phaseWait` and `phaseHold` is 1 in every busy cycle, and none is 1 when idle. The phases run in the order setup, wait, hold. Setup lasts the base count (1, 2 or 3 cycles). Wait lasts the wait field plus, for writes, the extra-write field. Hold lasts the hold field.
- R10: Configuration inputs and `reqWrite` are sampled at acceptance. Changing them during an access changes neither its length nor its phases.
- R11: During and after reset, `busy`, `ready`, `decodeErr` and all phase strobes are 0 and `regionSel` is 6. A reset in the middle of an access returns the block to idle.
- R12: `regionSel` codes: flash 0, static RAM 1, data EEPROM 2, peripheral 3, port 4, idle 6, unmapped 7. The code stays constant for the whole access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Access request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 16 | Access address |
| flashFastRd | input | 1 | Flash fast-read enable |
| flashWait | input | 3 | Flash wait cycles |
| flashHold | input | 3 | Flash hold cycles |
| extraWr | input | 3 | Extra write cycles (flash and port writes) |
| eeZeroWs | input | 1 | Data EEPROM zero-wait-state select |
| ioWait | input | 3 | Port wait cycles |
| ioHold | input | 3 | Port hold cycles |
| regionSel | output | 3 | Region code of the current access |
| phaseSetup | output | 1 | Setup-phase strobe |
| phaseWait | output | 1 | Wait-phase strobe |
| phaseHold | output | 1 | Hold-phase strobe |
| busy | output | 1 | Access in progress |
| ready | output | 1 | Final-cycle pulse |
| decodeErr | output | 1 | Unmapped address flag |

## Verification
Each region is exercised at its lowest and highest address, and also just outside its window, so that a misplaced boundary shows up as a wrong region code or length. Reads and writes are run with the same field values, which separates the read and write formulas. Nonzero wait, hold and extra fields are applied to regions that must ignore them, which exposes any field leaking into the wrong region. The per-phase cycle counts are checked as well as the total, so a swap between the wait and hold fields is caught even when the sum stays the same. Changing the configuration mid-access, holding the request high across an access, and resetting mid-access test sampling, acceptance and recovery.

// File: rtl/access_pacer_pkg.sv
package access_pacer_pkg;

  typedef enum logic [2:0] {
    RG_FLASH = 3'd0,
    RG_SRAM  = 3'd1,
    RG_DEE   = 3'd2,
    RG_PERI  = 3'd3,
    RG_PORT  = 3'd4,
    RG_IDLE  = 3'd6,
    RG_NONE  = 3'd7
  } region_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_WAIT  = 2'd2,
    ST_HOLD  = 2'd3
  } state_e;

  // control -> datapath
  typedef struct packed {
    logic capture;
    logic loadSetup;
    logic loadWait;
    logic loadHold;
    logic countDown;
  } ctl_strobe_t;

  // datapath -> control
  typedef struct packed {
    logic cntZero;
    logic waitEmpty;
    logic holdEmpty;
  } dp_status_t;

endpackage

// File: rtl/access_pacer_decode.sv
module access_pacer_decode
  import access_pacer_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter logic [ADDR_W-1:0] FLASH_HI = 16'hBFFF,
  parameter logic [ADDR_W-1:0] SRAM_LO  = 16'hC000,
  parameter logic [ADDR_W-1:0] SRAM_HI  = 16'hCBFF,
  parameter logic [ADDR_W-1:0] DEE_LO   = 16'hF000,
  parameter logic [ADDR_W-1:0] DEE_HI   = 16'hF27F,
  parameter logic [ADDR_W-1:0] PORT_LO  = 16'hFB00,
  parameter logic [ADDR_W-1:0] PORT_HI  = 16'hFBFF,
  parameter logic [ADDR_W-1:0] PERI_LO  = 16'hF800
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region
);

  // Flash starts at zero; peripherals run to the top of the space.
  always_comb begin
    if (addr <= FLASH_HI)                          region = RG_FLASH;
    else if (addr >= SRAM_LO && addr <= SRAM_HI)   region = RG_SRAM;
    else if (addr >= DEE_LO && addr <= DEE_HI)     region = RG_DEE;
    else if (addr >= PORT_LO && addr <= PORT_HI)   region = RG_PORT;
    else if (addr >= PERI_LO)                      region = RG_PERI;
    else                                           region = RG_NONE;
  end

endmodule

// File: rtl/access_pacer_dp.sv
module access_pacer_dp
  import access_pacer_pkg::*;
#(
  parameter int FIELD_W = 3,
  parameter int CNT_W   = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctl_strobe_t        strobe,
  input  region_e            regionIn,
  input  logic               isWrite,
  input  logic               flashFastRd,
  input  logic [FIELD_W-1:0] flashWait,
  input  logic [FIELD_W-1:0] flashHold,
  input  logic [FIELD_W-1:0] extraWr,
  input  logic               eeZeroWs,
  input  logic [FIELD_W-1:0] ioWait,
  input  logic [FIELD_W-1:0] ioHold,
  output dp_status_t         status,
  output region_e            regionQ
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] setupLen, waitLen, holdLen;
  logic [CNT_W-1:0] waitQ, holdQ, cnt;
  logic [CNT_W-1:0] extraLen;

  assign extraLen = isWrite ? CNT_W'(extraWr) : '0;

  // Phase lengths from the live inputs; used only in the accept cycle.
  always_comb begin
    setupLen = ONE;
    waitLen  = '0;
    holdLen  = '0;
    unique case (regionIn)
      RG_FLASH: begin
        if (flashFastRd) begin
          setupLen = ONE;
          waitLen  = extraLen;
        end else begin
          setupLen = CNT_W'(2);
          waitLen  = CNT_W'(flashWait) + extraLen;
          holdLen  = CNT_W'(flashHold);
        end
      end
      RG_DEE:  setupLen = eeZeroWs ? ONE : CNT_W'(2);
      RG_PERI: setupLen = CNT_W'(2);
      RG_PORT: begin
        setupLen = CNT_W'(3);
        waitLen  = CNT_W'(ioWait) + extraLen;
        holdLen  = CNT_W'(ioHold);
      end
      default: setupLen = ONE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      waitQ   <= '0;
      holdQ   <= '0;
      regionQ <= RG_IDLE;
    end else if (strobe.capture) begin
      waitQ   <= waitLen;
      holdQ   <= holdLen;
      regionQ <= regionIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 cnt <= '0;
    else if (strobe.loadSetup) cnt <= setupLen - ONE;
    else if (strobe.loadWait)  cnt <= waitQ - ONE;
    else if (strobe.loadHold)  cnt <= holdQ - ONE;
    else if (strobe.countDown) cnt <= cnt - ONE;
  end

  assign status.cntZero   = (cnt == '0);
  assign status.waitEmpty = (waitQ == '0);
  assign status.holdEmpty = (holdQ == '0);

endmodule

// File: rtl/access_pacer_ctrl.sv
module access_pacer_ctrl
  import access_pacer_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  dp_status_t  status,
  output ctl_strobe_t strobe,
  output logic        phaseSetup,
  output logic        phaseWait,
  output logic        phaseHold,
  output logic        busy,
  output logic        ready
);

  state_e state, stateNext;

  always_comb begin
    strobe    = '0;
    stateNext = state;
    ready     = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strobe.capture   = 1'b1;
          strobe.loadSetup = 1'b1;
          stateNext        = ST_SETUP;
        end
      end
      ST_SETUP: begin
        if (!status.cntZero) begin
          strobe.countDown = 1'b1;
        end else if (!status.waitEmpty) begin
          strobe.loadWait = 1'b1;
          stateNext       = ST_WAIT;
        end else if (!status.holdEmpty) begin
          strobe.loadHold = 1'b1;
          stateNext       = ST_HOLD;
        end else begin
          ready     = 1'b1;
          stateNext = ST_IDLE;
        end
      end
      ST_WAIT: begin
        if (!status.cntZero) begin
          strobe.countDown = 1'b1;
        end else if (!status.holdEmpty) begin
          strobe.loadHold = 1'b1;
          stateNext       = ST_HOLD;
        end else begin
          ready     = 1'b1;
          stateNext = ST_IDLE;
        end
      end
      ST_HOLD: begin
        if (!status.cntZero) begin
          strobe.countDown = 1'b1;
        end else begin
          ready     = 1'b1;
          stateNext = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign phaseSetup = (state == ST_SETUP);
  assign phaseWait  = (state == ST_WAIT);
  assign phaseHold  = (state == ST_HOLD);
  assign busy       = (state != ST_IDLE);

endmodule

// File: rtl/access_pacer.sv
module access_pacer
  import access_pacer_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int FIELD_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic               reqWrite,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic               flashFastRd,
  input  logic [FIELD_W-1:0] flashWait,
  input  logic [FIELD_W-1:0] flashHold,
  input  logic [FIELD_W-1:0] extraWr,
  input  logic               eeZeroWs,
  input  logic [FIELD_W-1:0] ioWait,
  input  logic [FIELD_W-1:0] ioHold,
  output logic [2:0]         regionSel,
  output logic               phaseSetup,
  output logic               phaseWait,
  output logic               phaseHold,
  output logic               busy,
  output logic               ready,
  output logic               decodeErr
);

  // Longest access: base 3 + wait + extra + hold, all fields at maximum.
  localparam int FIELD_MAX = (1 << FIELD_W) - 1;
  localparam int LEN_MAX   = 3 + 3 * FIELD_MAX;
  localparam int CNT_W     = $clog2(LEN_MAX + 1);

  region_e     regionLive, regionQ;
  ctl_strobe_t strobe;
  dp_status_t  status;

  access_pacer_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr   (reqAddr),
    .region (regionLive)
  );

  access_pacer_dp #(.FIELD_W(FIELD_W), .CNT_W(CNT_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .regionIn    (regionLive),
    .isWrite     (reqWrite),
    .flashFastRd (flashFastRd),
    .flashWait   (flashWait),
    .flashHold   (flashHold),
    .extraWr     (extraWr),
    .eeZeroWs    (eeZeroWs),
    .ioWait      (ioWait),
    .ioHold      (ioHold),
    .status      (status),
    .regionQ     (regionQ)
  );

  access_pacer_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .status     (status),
    .strobe     (strobe),
    .phaseSetup (phaseSetup),
    .phaseWait  (phaseWait),
    .phaseHold  (phaseHold),
    .busy       (busy),
    .ready      (ready)
  );

  assign regionSel = busy ? regionQ : RG_IDLE;
  assign decodeErr = busy && (regionQ == RG_NONE);

endmodule

// File: rtl/access_pacer_chk.sv
module access_pacer_chk (
  input logic       clk,
  input logic       rstN,
  input logic [2:0] regionSel,
  input logic       phaseSetup,
  input logic       phaseWait,
  input logic       phaseHold,
  input logic       busy,
  input logic       ready,
  input logic       decodeErr
);

  p_ready_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    ready |=> !ready);

  p_ready_in_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    ready |-> busy);

  p_idle_after_ready_r8: assert property (@(posedge clk) disable iff (!rstN)
    ready |=> !busy);

  p_phase_onehot_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({phaseSetup, phaseWait, phaseHold})
    && (busy == (phaseSetup | phaseWait | phaseHold)));

  p_hold_last_r9: assert property (@(posedge clk) disable iff (!rstN)
    phaseHold |=> !phaseSetup && !phaseWait);

  p_wait_no_setup_r9: assert property (@(posedge clk) disable iff (!rstN)
    phaseWait |=> !phaseSetup);

  p_region_stable_r12: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !ready) |=> busy && $stable(regionSel));

  p_idle_code_r12: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> regionSel == 3'd6);

  p_err_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    decodeErr |-> ready && regionSel == 3'd7);

  p_sram_single_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busy && regionSel == 3'd1) |-> ready);

endmodule

bind access_pacer access_pacer_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .regionSel  (regionSel),
  .phaseSetup (phaseSetup),
  .phaseWait  (phaseWait),
  .phaseHold  (phaseHold),
  .busy       (busy),
  .ready      (ready),
  .decodeErr  (decodeErr)
);

// File: tb/access_pacer_tb.sv
module access_pacer_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0;
  logic       reqWrite = 1'b0;
  logic [15:0] reqAddr = '0;
  logic       flashFastRd = 1'b0;
  logic [2:0] flashWait = '0, flashHold = '0, extraWr = '0;
  logic       eeZeroWs = 1'b0;
  logic [2:0] ioWait = '0, ioHold = '0;
  logic [2:0] regionSel;
  logic       phaseSetup, phaseWait, phaseHold, busy, ready, decodeErr;

  int nRun = 0;
  int nFail = 0;

  always #2 clk = ~clk;  // 250 MHz

  access_pacer u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .flashFastRd(flashFastRd), .flashWait(flashWait),
    .flashHold(flashHold), .extraWr(extraWr), .eeZeroWs(eeZeroWs),
    .ioWait(ioWait), .ioHold(ioHold), .regionSel(regionSel),
    .phaseSetup(phaseSetup), .phaseWait(phaseWait), .phaseHold(phaseHold),
    .busy(busy), .ready(ready), .decodeErr(decodeErr)
  );

  typedef struct packed {
    logic [15:0] addr;
    logic        wr;
    logic        fast;
    logic        zws;
    logic [2:0]  fw, fh, ex, iw, ih;
    logic [2:0]  rg;
    logic [4:0]  s, w, h;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VECS [NV] = '{
    '{16'h0100, 1'b0, 1'b1, 1'b0, 3'd3, 3'd2, 3'd4, 3'd1, 3'd1, 3'd0, 5'd1, 5'd0,  5'd0},
    '{16'h0100, 1'b0, 1'b0, 1'b0, 3'd3, 3'd2, 3'd4, 3'd1, 3'd1, 3'd0, 5'd2, 5'd3,  5'd2},
    '{16'hBFFF, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 5'd2, 5'd0,  5'd0},
    '{16'h2000, 1'b1, 1'b1, 1'b0, 3'd5, 3'd5, 3'd4, 3'd0, 3'd0, 3'd0, 5'd1, 5'd4,  5'd0},
    '{16'h2000, 1'b1, 1'b0, 1'b0, 3'd1, 3'd3, 3'd2, 3'd0, 3'd0, 3'd0, 5'd2, 5'd3,  5'd3},
    '{16'h0000, 1'b1, 1'b0, 1'b0, 3'd7, 3'd7, 3'd7, 3'd0, 3'd0, 3'd0, 5'd2, 5'd14, 5'd7},
    '{16'hC000, 1'b0, 1'b0, 1'b0, 3'd7, 3'd7, 3'd7, 3'd7, 3'd7, 3'd1, 5'd1, 5'd0,  5'd0},
    '{16'hCBFF, 1'b1, 1'b0, 1'b0, 3'd7, 3'd7, 3'd7, 3'd7, 3'd7, 3'd1, 5'd1, 5'd0,  5'd0},
    '{16'hF000, 1'b0, 1'b0, 1'b1, 3'd7, 3'd7, 3'd7, 3'd7, 3'd7, 3'd2, 5'd1, 5'd0,  5'd0},
    '{16'hF27F, 1'b1, 1'b1, 1'b0, 3'd7, 3'd7, 3'd7, 3'd7, 3'd7, 3'd2, 5'd2, 5'd0,  5'd0},
    '{16'hF800, 1'b0, 1'b0, 1'b1, 3'd7, 3'd7, 3'd7, 3'd7, 3'd7, 3'd3, 5'd2, 5'd0,  5'd0},
    '{16'hFC00, 1'b1, 1'b0, 1'b0, 3'd7, 3'd7, 3'd7, 3'd7, 3'd7, 3'd3, 5'd2, 5'd0,  5'd0},
    '{16'hFFFF, 1'b1, 1'b1, 1'b1, 3'd7, 3'd7, 3'd7, 3'd7, 3'd7, 3'd3, 5'd2, 5'd0,  5'd0},
    '{16'hFB00, 1'b0, 1'b0, 1'b0, 3'd7, 3'd7, 3'd5, 3'd2, 3'd1, 3'd4, 5'd3, 5'd2,  5'd1},
    '{16'hFBFF, 1'b1, 1'b0, 1'b0, 3'd7, 3'd7, 3'd5, 3'd2, 3'd1, 3'd4, 5'd3, 5'd7,  5'd1},
    '{16'hFB80, 1'b1, 1'b1, 1'b1, 3'd0, 3'd0, 3'd7, 3'd7, 3'd7, 3'd4, 5'd3, 5'd14, 5'd7},
    '{16'hFB40, 1'b0, 1'b0, 1'b0, 3'd7, 3'd7, 3'd7, 3'd0, 3'd0, 3'd4, 5'd3, 5'd0,  5'd0},
    '{16'hCC00, 1'b0, 1'b0, 1'b0, 3'd7, 3'd7, 3'd7, 3'd7, 3'd7, 3'd7, 5'd1, 5'd0,  5'd0},
    '{16'hF280, 1'b1, 1'b0, 1'b0, 3'd7, 3'd7, 3'd7, 3'd7, 3'd7, 3'd7, 5'd1, 5'd0,  5'd0},
    '{16'hF7FF, 1'b0, 1'b0, 1'b0, 3'd7, 3'd7, 3'd7, 3'd7, 3'd7, 3'd7, 5'd1, 5'd0,  5'd0},
    '{16'hE000, 1'b1, 1'b0, 1'b0, 3'd7, 3'd7, 3'd7, 3'd7, 3'd7, 3'd7, 5'd1, 5'd0,  5'd0}
  };

  function automatic string tagOf(input int i);
    if (i < 3)  return "R1";
    if (i < 6)  return "R2";
    if (i < 8)  return "R3";
    if (i < 10) return "R4";
    if (i < 13) return "R5";
    if (i < 17) return "R6";
    return "R7";
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic applyCfg(input vec_t v);
    reqAddr = v.addr; reqWrite = v.wr; flashFastRd = v.fast; eeZeroWs = v.zws;
    flashWait = v.fw; flashHold = v.fh; extraWr = v.ex; ioWait = v.iw; ioHold = v.ih;
  endtask

  // Present one request, follow it to ready, and report per-phase counts.
  task automatic runAccess(input vec_t v, input bit scramble,
                           output int s, output int w, output int h,
                           output int rg, output bit err, output bit idleAfter);
    s = 0; w = 0; h = 0; rg = -1; err = 1'b0; idleAfter = 1'b0;
    @(negedge clk);
    applyCfg(v);
    reqValid = 1'b1;
    @(negedge clk);               // accept edge has passed
    reqValid = 1'b0;
    for (int n = 0; n < 40; n++) begin
      if (phaseSetup) s++;
      if (phaseWait)  w++;
      if (phaseHold)  h++;
      if (rg < 0) rg = int'(regionSel);
      if (decodeErr) err = 1'b1;
      if (n == 0 && scramble) begin
        flashFastRd = ~flashFastRd; flashWait = 3'd7; flashHold = 3'd7;
        extraWr = 3'd7; reqWrite = ~reqWrite; reqAddr = 16'hFB00;
      end
      if (ready) begin
        @(negedge clk);
        idleAfter = !busy;
        return;
      end
      @(negedge clk);
    end
    check(1'b0, "R8", "ready timeout", 0, 1);
  endtask

  initial begin
    #400000;
    nRun++; nFail++;
    $display("FAIL R8 watchdog expired: actual 0 expected 1");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    int s, w, h, rg;
    bit err, idleAfter;
    vec_t v;

    // R11: reset state
    repeat (3) @(negedge clk);
    check(!busy && !ready && !decodeErr, "R11", "busy/ready/err in reset", {busy, ready, decodeErr}, 0);
    check({phaseSetup, phaseWait, phaseHold} == 3'b000, "R11", "phases in reset",
          {phaseSetup, phaseWait, phaseHold}, 0);
    check(regionSel == 3'd6, "R11", "regionSel in reset", regionSel, 6);
    rstN = 1'b1;
    @(negedge clk);
    check(regionSel == 3'd6 && !busy, "R11", "idle after reset", regionSel, 6);

    // Table walk: R1..R7, R9, R12
    for (int i = 0; i < NV; i++) begin
      v = VECS[i];
      runAccess(v, 1'b0, s, w, h, rg, err, idleAfter);
      check(s + w + h == int'(v.s + v.w + v.h), tagOf(i), $sformatf("vec %0d length", i),
            s + w + h, v.s + v.w + v.h);
      check(s == int'(v.s) && w == int'(v.w) && h == int'(v.h), "R9",
            $sformatf("vec %0d phase split s%0d w%0d h%0d", i, s, w, h),
            s * 10000 + w * 100 + h, v.s * 10000 + v.w * 100 + v.h);
      check(rg == int'(v.rg), "R12", $sformatf("vec %0d region code", i), rg, v.rg);
      check(err == (v.rg == 3'd7), "R7", $sformatf("vec %0d decodeErr", i), err, v.rg == 3'd7);
      check(idleAfter, "R8", $sformatf("vec %0d idle after ready", i), idleAfter, 1);
    end

    // R10: configuration changed during access has no effect
    v = '{16'h0400, 1'b0, 1'b0, 1'b0, 3'd2, 3'd2, 3'd0, 3'd0, 3'd0, 3'd0, 5'd2, 5'd2, 5'd2};
    runAccess(v, 1'b1, s, w, h, rg, err, idleAfter);
    check(s == 2 && w == 2 && h == 2, "R10", "mid-access config change",
          s * 10000 + w * 100 + h, 20202);
    check(rg == 0, "R10", "region kept after address change", rg, 0);

    // R8: request held high across an access is taken only after idle cycle
    @(negedge clk);
    v = '{16'hC010, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd1, 5'd1, 5'd0, 5'd0};
    applyCfg(v);
    reqValid = 1'b1;
    @(negedge clk);
    check(busy && ready, "R8", "sram accept with req held", {busy, ready}, 3);
    @(negedge clk);
    check(!busy, "R8", "idle cycle after ready while req held", busy, 0);
    @(negedge clk);
    check(busy && ready, "R8", "second request accepted after idle", {busy, ready}, 3);
    reqValid = 1'b0;
    @(negedge clk);

    // R8: request during a long access is ignored (access length unchanged)
    v = '{16'hFB20, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0, 3'd0, 3'd3, 3'd0, 3'd4, 5'd3, 5'd3, 5'd0};
    applyCfg(v);
    reqValid = 1'b1;
    @(negedge clk);
    reqAddr = 16'hC000;         // would be a 1-cycle access if taken
    s = 1;
    while (!ready && s < 40) begin @(negedge clk); s++; end
    check(s == 6, "R8", "request while busy ignored", s, 6);
    reqValid = 1'b0;
    @(negedge clk);

    // R11: reset in the middle of an access
    applyCfg('{16'hFB00, 1'b1, 1'b0, 1'b0, 3'd0, 3'd0, 3'd7, 3'd7, 3'd7, 3'd4, 5'd3, 5'd14, 5'd7});
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b0;
    #1;
    check(!busy && !ready && regionSel == 3'd6, "R11", "mid-access reset",
          {busy, ready, regionSel}, 6);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && {phaseSetup, phaseWait, phaseHold} == 3'b000, "R11", "idle after mid reset",
          busy, 0);

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule